// File: doc/BRIEF.md
# Compressed reference fetch address generator

This block turns a motion-compensation reference request into the stream of external memory word addresses needed to bring in the compressed reference data. The reference frame is held in external memory as a grid of 4x4 pixel blocks. Each block is compressed to a fixed 64-bit segment, which is a ratio of two. Because memory words are 32 bits, every coded block is read as two consecutive words.

A request gives the block-grid position of the target 4x4 block and a motion vector with an integer part and a 2-bit fractional part on each axis. For each axis, the block works out which coded blocks cover the pixels that interpolation needs. It clamps those blocks to the frame and emits one word address per cycle, in raster order, under a valid/ready handshake. A done flag tells the requester when a new request may be issued.

The number of words depends only on the alignment class of each axis. It ranges from 2 words for a fully aligned request to 18 words when both axes are sub-pixel.

Top module: `fetch_addr_gen`

## Requirements
- R1: Coded block (col, row) occupies word addresses FRAME_BASE + 2*(row*BLK_COLS + col) and that address + 1. Its two words are issued back to back, lower address first.
- R2: An axis whose pixel position p = 4*block_index + mv_int has a zero fraction and p mod 4 = 0 covers exactly one coded block, number p/4.
- R3: An axis with a zero fraction and p mod 4 != 0 covers two coded blocks, floor(p/4) and floor(p/4)+1.
- R4: An axis with a non-zero fraction (any of the values 1, 2 or 3 in quarter-pel units) needs pixels p-2 through p+6. It covers three coded blocks, starting at floor((p-2)/4).
- R5: A request issues 2 * (blocks on x) * (blocks on y) word addresses. That is 2 when both axes are aligned and 18 when both are sub-pixel.
- R6: Blocks are visited row by row from the top, and left to right within a row.
- R7: Any block column below 0 or above BLK_COLS-1, and any block row below 0 or above BLK_ROWS-1, is replaced by the nearest edge block. The block is still fetched in its sequence slot.
- R8: While fetch_valid is high and fetch_ready is low, fetch_valid and fetch_addr stay unchanged.
- R9: req_done is high after reset and whenever the block is idle, and fetch_valid is low while req_done is high. A start accepted on a clock edge drops req_done and raises fetch_valid with the first address on the next cycle. req_done returns high on the cycle after the handshake of the last word.
- R10: req_start while req_done is low is ignored, and the request in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Request pulse, taken only while req_done is high |
| req_col | input | COL_W | Block-grid column of the target 4x4 block |
| req_row | input | ROW_W | Block-grid row of the target 4x4 block |
| mv_x_int | input | MV_W | Signed integer horizontal motion, in pixels |
| mv_x_frac | input | 2 | Horizontal quarter-pel fraction |
| mv_y_int | input | MV_W | Signed integer vertical motion, in pixels |
| mv_y_frac | input | 2 | Vertical quarter-pel fraction |
| fetch_ready | input | 1 | Memory side accepts the current address |
| fetch_valid | output | 1 | fetch_addr holds a word address to fetch |
| fetch_addr | output | ADDR_W | External word address |
| req_done | output | 1 | Idle; a new request may be started |

## Verification
The hardest case to reach from the ports is a window whose clamped blocks repeat while the cursor is held by back-pressure in the middle of a block pair. This needs a motion vector that pushes a sub-pixel window past a frame corner, together with a ready pattern that drops exactly between the two words of a block. The stimulus sweeps every block position of a small 6x5 frame against positive and negative motion values, including values that cross each edge, under all four fraction combinations. It drives ready from a pseudo-random sequence so that stalls land on every word position. A directed case then pulses a new start with different operands while the first address is stalled, and confirms that the sequence is unchanged.

// File: rtl/fa_pkg.sv
package fa_pkg;

   // Number of coded blocks one axis of a request covers; value equals count.
   typedef enum logic [1:0] {
      SPAN_ONE   = 2'd1,
      SPAN_TWO   = 2'd2,
      SPAN_THREE = 2'd3
   } span_e;

   // Words per coded block: 64-bit segment over a 32-bit memory word.
   localparam int WORDS_PER_BLOCK = 2;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/fa_axis_span.sv
module fa_axis_span
   import fa_pkg::*;
#(
   parameter int IDX_W = 3,
   parameter int MV_W  = 6,
   parameter int PIX_W = 10
) (
   input  logic [IDX_W-1:0]        blk,
   input  logic signed [MV_W-1:0]  mv_int,
   input  logic [1:0]              mv_frac,
   output logic signed [PIX_W-1:0] first_blk,
   output span_e                   span
);

   logic signed [PIX_W-1:0] pos;
   logic signed [PIX_W-1:0] pos_lead;
   logic                    is_sub;
   logic                    on_grid;

   always_comb begin
      pos      = PIX_W'(signed'({1'b0, blk, 2'b00})) + PIX_W'(mv_int);
      pos_lead = pos - PIX_W'(2);
      is_sub   = |mv_frac;
      on_grid  = (pos[1:0] == 2'b00);
      if (is_sub) begin
         first_blk = pos_lead >>> 2;
         span      = SPAN_THREE;
      end else if (on_grid) begin
         first_blk = pos >>> 2;
         span      = SPAN_ONE;
      end else begin
         first_blk = pos >>> 2;
         span      = SPAN_TWO;
      end
   end

endmodule

// File: rtl/fa_clamp.sv
module fa_clamp #(
   parameter int PIX_W = 10,
   parameter int IDX_W = 3,
   parameter int LIMIT = 6
) (
   input  logic signed [PIX_W-1:0] coord,
   output logic [IDX_W-1:0]        idx
);

   localparam logic signed [PIX_W-1:0] TOP = PIX_W'(LIMIT - 1);

   always_comb begin
      if (coord < 0)
         idx = '0;
      else if (coord > TOP)
         idx = IDX_W'(LIMIT - 1);
      else
         idx = coord[IDX_W-1:0];
   end

endmodule

// File: rtl/fa_walker.sv
module fa_walker
   import fa_pkg::*;
#(
   parameter int                BLK_COLS   = 6,
   parameter int                BLK_ROWS   = 5,
   parameter int                PIX_W      = 10,
   parameter int                IDX_W      = 3,
   parameter int                ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] FRAME_BASE = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic signed [PIX_W-1:0] first_x,
   input  logic signed [PIX_W-1:0] first_y,
   input  span_e                   span_x,
   input  span_e                   span_y,
   input  logic                    ready,
   output logic                    valid,
   output logic [ADDR_W-1:0]       addr,
   output logic                    busy
);

   localparam logic [ADDR_W:0] ADDR_END =
      (ADDR_W+1)'(FRAME_BASE) + (ADDR_W+1)'(WORDS_PER_BLOCK * BLK_COLS * BLK_ROWS);

   logic signed [PIX_W-1:0] org_q [2];
   logic [1:0]              cnt_q [2];
   logic [1:0]              cur_q [2];
   logic                    half_q;
   logic                    busy_q;
   logic signed [PIX_W-1:0] coord [2];
   logic [IDX_W-1:0]        cidx  [2];
   logic                    step;
   logic                    col_last;
   logic                    row_last;
   logic [ADDR_W-1:0]       lin;

   // One cursor and clamp per axis.
   for (genvar a = 0; a < 2; a++) begin : g_ax
      localparam int LIM = (a == 0) ? BLK_COLS : BLK_ROWS;
      assign coord[a] = org_q[a] + PIX_W'(signed'({1'b0, cur_q[a]}));
      fa_clamp #(.PIX_W(PIX_W), .IDX_W(IDX_W), .LIMIT(LIM)) i_clamp (
         .coord (coord[a]),
         .idx   (cidx[a])
      );
   end

   assign step     = busy_q && ready;
   assign col_last = (cur_q[0] == cnt_q[0] - 2'd1);
   assign row_last = (cur_q[1] == cnt_q[1] - 2'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         half_q   <= 1'b0;
         org_q[0] <= '0;
         org_q[1] <= '0;
         cnt_q[0] <= 2'd1;
         cnt_q[1] <= 2'd1;
         cur_q[0] <= '0;
         cur_q[1] <= '0;
      end else if (load && !busy_q) begin
         busy_q   <= 1'b1;
         half_q   <= 1'b0;
         org_q[0] <= first_x;
         org_q[1] <= first_y;
         cnt_q[0] <= 2'(span_x);
         cnt_q[1] <= 2'(span_y);
         cur_q[0] <= '0;
         cur_q[1] <= '0;
      end else if (step) begin
         half_q <= ~half_q;
         if (half_q) begin
            if (!col_last) begin
               cur_q[0] <= cur_q[0] + 2'd1;
            end else begin
               cur_q[0] <= '0;
               if (row_last)
                  busy_q <= 1'b0;
               else
                  cur_q[1] <= cur_q[1] + 2'd1;
            end
         end
      end
   end

   always_comb begin
      lin  = ADDR_W'(cidx[1]) * ADDR_W'(BLK_COLS) + ADDR_W'(cidx[0]);
      addr = FRAME_BASE + (lin << 1) + ADDR_W'(half_q);
   end

   assign valid = busy_q;
   assign busy  = busy_q;

   // R1: the second word of a block immediately follows the first.
   p_word_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
      valid && ready && !half_q |=> valid && (addr == $past(addr) + ADDR_W'(1)));

   // R7: every issued address lies inside the frame.
   p_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> ({1'b0, addr} >= (ADDR_W+1)'(FRAME_BASE)) && ({1'b0, addr} < ADDR_END));

   // R8: back-pressure holds the address.
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !ready |=> valid && $stable(addr));

endmodule

// File: rtl/fetch_addr_gen.sv
module fetch_addr_gen
   import fa_pkg::*;
#(
   parameter int                BLK_COLS   = 6,
   parameter int                BLK_ROWS   = 5,
   parameter int                MV_W       = 6,
   parameter int                ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] FRAME_BASE = 16'h0100,
   parameter int                COL_W      = idx_bits(BLK_COLS),
   parameter int                ROW_W      = idx_bits(BLK_ROWS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_start,
   input  logic [COL_W-1:0]       req_col,
   input  logic [ROW_W-1:0]       req_row,
   input  logic signed [MV_W-1:0] mv_x_int,
   input  logic [1:0]             mv_x_frac,
   input  logic signed [MV_W-1:0] mv_y_int,
   input  logic [1:0]             mv_y_frac,
   input  logic                   fetch_ready,
   output logic                   fetch_valid,
   output logic [ADDR_W-1:0]      fetch_addr,
   output logic                   req_done
);

   localparam int IDX_W = max2(COL_W, ROW_W);
   localparam int PIX_W = max2(IDX_W + 2, MV_W) + 2;
   localparam int NEED_A = $clog2(WORDS_PER_BLOCK * BLK_COLS * BLK_ROWS) + 1;

   if (BLK_COLS < 2 || BLK_ROWS < 2) begin : g_bad_dims
      $error("fetch_addr_gen: frame must be at least 2x2 blocks");
   end
   if (ADDR_W < NEED_A) begin : g_bad_addr
      $error("fetch_addr_gen: ADDR_W too narrow for the frame");
   end
   if (MV_W < 3) begin : g_bad_mv
      $error("fetch_addr_gen: MV_W too narrow");
   end

   logic [IDX_W-1:0]        blk_a   [2];
   logic signed [MV_W-1:0]  mvi_a   [2];
   logic [1:0]              mvf_a   [2];
   logic signed [PIX_W-1:0] first_a [2];
   span_e                   span_a  [2];
   logic                    busy;

   assign blk_a[0] = IDX_W'(req_col);
   assign blk_a[1] = IDX_W'(req_row);
   assign mvi_a[0] = mv_x_int;
   assign mvi_a[1] = mv_y_int;
   assign mvf_a[0] = mv_x_frac;
   assign mvf_a[1] = mv_y_frac;

   for (genvar a = 0; a < 2; a++) begin : g_axis
      fa_axis_span #(.IDX_W(IDX_W), .MV_W(MV_W), .PIX_W(PIX_W)) i_span (
         .blk       (blk_a[a]),
         .mv_int    (mvi_a[a]),
         .mv_frac   (mvf_a[a]),
         .first_blk (first_a[a]),
         .span      (span_a[a])
      );
   end

   fa_walker #(
      .BLK_COLS   (BLK_COLS),
      .BLK_ROWS   (BLK_ROWS),
      .PIX_W      (PIX_W),
      .IDX_W      (IDX_W),
      .ADDR_W     (ADDR_W),
      .FRAME_BASE (FRAME_BASE)
   ) i_walker (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (req_start),
      .first_x (first_a[0]),
      .first_y (first_a[1]),
      .span_x  (span_a[0]),
      .span_y  (span_a[1]),
      .ready   (fetch_ready),
      .valid   (fetch_valid),
      .addr    (fetch_addr),
      .busy    (busy)
   );

   assign req_done = !busy;

   // R9: an accepted start yields a valid address on the next cycle.
   p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_start && req_done |=> !req_done && fetch_valid);

   // R9: no address is offered while idle.
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |-> !fetch_valid);

   // R10: a start while busy does not disturb a stalled address.
   p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_start && !req_done && !fetch_ready |=> !req_done && $stable(fetch_addr));

endmodule

// File: tb/test_fetch_addr_gen.sv
module test_fetch_addr_gen;

   localparam int CLK_PERIOD = 10;
   localparam int COLS = 6;
   localparam int ROWS = 5;
   localparam int MVW  = 6;
   localparam int AW   = 16;
   localparam logic [AW-1:0] BASE = 16'h0100;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_start = 1'b0;
   logic [2:0]      req_col = '0;
   logic [2:0]      req_row = '0;
   logic signed [MVW-1:0] mv_x_int = '0;
   logic [1:0]      mv_x_frac = '0;
   logic signed [MVW-1:0] mv_y_int = '0;
   logic [1:0]      mv_y_frac = '0;
   logic            fetch_ready = 1'b0;
   logic            fetch_valid;
   logic [AW-1:0]   fetch_addr;
   logic            req_done;

   int tests = 0;
   int fails = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #(CLK_PERIOD/2) clk = ~clk;

   fetch_addr_gen #(
      .BLK_COLS(COLS), .BLK_ROWS(ROWS), .MV_W(MVW), .ADDR_W(AW), .FRAME_BASE(BASE)
   ) i_fetch_addr_gen (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_col(req_col),
      .req_row(req_row), .mv_x_int(mv_x_int), .mv_x_frac(mv_x_frac),
      .mv_y_int(mv_y_int), .mv_y_frac(mv_y_frac), .fetch_ready(fetch_ready),
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .req_done(req_done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int fl4(input int v);
      return (v >= 0) ? v / 4 : -((-v + 3) / 4);
   endfunction

   function automatic int clampi(input int v, input int lim);
      return (v < 0) ? 0 : ((v > lim - 1) ? lim - 1 : v);
   endfunction

   // R2 R3 R4: first block and block count of one axis.
   task automatic axis_model(input int b, input int mi, input int mf,
                             output int first, output int n);
      int p;
      p = b * 4 + mi;
      if (mf != 0) begin
         first = fl4(p - 2); n = 3;
      end else if (fl4(p) * 4 == p) begin
         first = fl4(p); n = 1;
      end else begin
         first = fl4(p); n = 2;
      end
   endtask

   task automatic step_lfsr();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   task automatic run_req(input int bx, input int by, input int mxi, input int mxf,
                          input int myi, input int myf, input bit free_run);
      int fx, nx, fy, ny, total, k, exp_a, h, c, r;
      logic [AW-1:0] held;
      bit stalled;
      axis_model(bx, mxi, mxf, fx, nx);
      axis_model(by, myi, myf, fy, ny);
      total = 2 * nx * ny;  // R5
      @(negedge clk);
      while (!req_done) @(negedge clk);
      req_col = 3'(bx); req_row = 3'(by);
      mv_x_int = MVW'(mxi); mv_x_frac = 2'(mxf);
      mv_y_int = MVW'(myi); mv_y_frac = 2'(myf);
      req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      check(!req_done && fetch_valid, "R9 accept", int'(fetch_valid), 1);
      k = 0;
      forever begin
         step_lfsr();
         fetch_ready = free_run ? 1'b1 : (lfsr[0] | lfsr[3]);
         if (!fetch_valid) begin
            check(1'b0, "R5 early end", k, total);
            break;
         end
         stalled = 1'b0;
         if (fetch_ready) begin
            h = k % 2; c = (k / 2) % nx; r = k / (2 * nx);
            // R1 R6 R7: raster order, pair of words, clamped block.
            exp_a = int'(BASE) + 2 * (clampi(fy + r, ROWS) * COLS + clampi(fx + c, COLS)) + h;
            check(int'(fetch_addr) == exp_a, "R1/R6/R7 address", int'(fetch_addr), exp_a);
            k++;
         end else begin
            held = fetch_addr; stalled = 1'b1;
         end
         @(negedge clk);
         if (stalled)
            check(fetch_valid && fetch_addr == held, "R8 stall hold", int'(fetch_addr), int'(held));
         if (k == total) begin
            check(req_done && !fetch_valid, "R9 done after last word", int'(req_done), 1);
            break;
         end
      end
      fetch_ready = 1'b0;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      int mvs [7] = '{-5, -2, 0, 1, 3, 4, 7};
      logic [AW-1:0] first_seen;
      repeat (3) @(negedge clk);
      check(req_done && !fetch_valid, "R9 reset state", int'(req_done), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_done && !fetch_valid, "R9 idle after reset", int'(fetch_valid), 0);

      // Directed corners: R2 fully aligned gives 2 words, R4 sub both gives 18.
      run_req(2, 2, 0, 0, 4, 0, 1'b1);
      run_req(0, 0, -1, 2, -1, 1, 1'b1);   // R7 top-left corner clamp
      run_req(5, 4, 3, 3, 3, 2, 1'b0);     // R7 bottom-right clamp
      run_req(1, 3, 1, 0, -3, 0, 1'b0);    // R3 both axes split

      // Sweep: all block positions, crossing motions, all fraction combinations.
      for (int by = 0; by < ROWS; by++)
         for (int bx = 0; bx < COLS; bx++)
            for (int ix = 0; ix < 7; ix++)
               for (int iy = 0; iy < 7; iy++)
                  for (int fm = 0; fm < 4; fm++)
                     run_req(bx, by, mvs[ix], (fm & 1) ? 1 : 0,
                             mvs[iy], (fm & 2) ? 3 : 0, 1'b0);

      // R10: start while busy is ignored.
      @(negedge clk);
      req_col = 3'd1; req_row = 3'd1; mv_x_int = '0; mv_x_frac = '0;
      mv_y_int = '0; mv_y_frac = '0; fetch_ready = 1'b0;
      req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      first_seen = fetch_addr;
      check(int'(first_seen) == int'(BASE) + 2 * (1 * COLS + 1), "R10 first address",
            int'(first_seen), int'(BASE) + 2 * (COLS + 1));
      req_col = 3'd4; req_row = 3'd3; mv_x_frac = 2'd2; req_start = 1'b1;
      @(negedge clk);
      @(negedge clk);
      req_start = 1'b0;
      check(!req_done && fetch_addr == first_seen, "R10 busy start ignored",
            int'(fetch_addr), int'(first_seen));
      fetch_ready = 1'b1;
      @(negedge clk);
      check(fetch_addr == first_seen + 1, "R10 sequence continues",
            int'(fetch_addr), int'(first_seen) + 1);
      @(negedge clk);
      check(req_done && !fetch_valid, "R10 original length kept", int'(req_done), 1);
      fetch_ready = 1'b0;

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule